// File: doc/BRIEF.md
# Power-Up Strap Latch Sequencer

This block brings a clock generator out of power-up in a fixed order. It stays idle until the supply-good indication is high. It then waits for the active-low strap-valid strobe. In the one cycle where that strobe is seen low, it captures the three-level mode select (already converted to a two-bit code), the two frequency-select straps and the current-multiplier strap. In the same cycle it starts the PLL. After a fixed number of reference-clock cycles, set by the `DLY` parameter, it enables the clock outputs.

The captured straps are decoded into three results:
- an operating mode: internal-synthesis, buffered-66-input, all-outputs-high-impedance or test-clock-divide;
- a CPU frequency in MHz;
- the divide ratios, as log2 values, that the test-clock mode applies to each output group.

A loss of supply-good at any point drops the block straight back to idle with the PLL and the outputs off. The held strap values survive that drop, but the next sequence replaces them.

Top module: `pwrseq_strap_top`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `supply_good` low, `pll_en` and `out_en` are both 0.
- R2: Straps are captured only on a clock edge where the block is waiting, `supply_good` is 1 and `strap_valid_n` is 0. `pll_en` rises in the cycle after that edge. A strobe that is held low while `supply_good` is low never starts the PLL.
- R3: `out_en` rises exactly `DLY` clock cycles after `pll_en` rises, and `out_en` is never 1 while `pll_en` is 0.
- R4: If `supply_good` falls during the PLL wait or while running, both enables are 0 one cycle later. Restoring `supply_good` with the strobe high does not restart the PLL.
- R5: Once captured, the decoded outputs and `mult_lat` do not change until the next capture. Strap or strobe activity after the capture edge, including a new low strobe while running, has no effect.
- R6: `sel_s2` code 2'b00 (low) selects internal mode (`clk_mode` 0). `sel_fs` values 00, 01, 10 and 11 then give `cpu_mhz` of 66, 100, 200 and 133.
- R7: `sel_s2` codes 2'b10 and 2'b11 (high) select buffered mode (`clk_mode` 1), with the same `cpu_mhz` mapping as R6.
- R8: `sel_s2` code 2'b01 (mid) with `sel_fs` of 00, 10 or 11 selects high-impedance mode (`clk_mode` 2), with `cpu_mhz` 0 and `tdiv_log2` 0.
- R9: `sel_s2` mid with `sel_fs` 01 selects test mode (`clk_mode` 3), with `cpu_mhz` 0. `tdiv_log2` packs 2-bit log2 divides as follows: [1:0] CPU=1, [3:2] 66 MHz group=2, [5:4] PCI=3, [7:6] REF=0, [9:8] 48 MHz=1, which gives 10'b01_00_11_10_01. In every other mode `tdiv_log2` is 0.
- R10: `mult_lat` equals the value `mult_sel` had on the capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_good | input | 1 | Supply above threshold |
| strap_valid_n | input | 1 | Active-low level strobe marking straps valid |
| sel_s2 | input | 2 | Three-level select code: 00 low, 01 mid, 10/11 high |
| sel_fs | input | 2 | Frequency-select straps |
| mult_sel | input | 1 | Current-multiplier strap |
| pll_en | output | 1 | PLL start |
| out_en | output | 1 | Clock output enable |
| clk_mode | output | 2 | 0 internal, 1 buffered, 2 high-Z, 3 test |
| cpu_mhz | output | 8 | Decoded CPU frequency in MHz, 0 in high-Z/test |
| tdiv_log2 | output | 10 | Packed test-mode divide exponents |
| mult_lat | output | 1 | Captured multiplier strap |

## Verification
Three events can land on the same clock edge, and each collision is driven on purpose:
- The strobe may go low on the very edge where supply-good has just returned, or is still low. The bench checks that only a strobe seen while waiting with good supply starts the PLL.
- Supply-good may drop partway through the enable delay. The bench counts cycles at the ports and expects both enables off one cycle later, with no restart until a fresh strobe arrives.
- A second low strobe carrying different straps may arrive while the block is running. The bench compares every decoded output against values computed from the first capture.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_LOCK = 2'd2,
        ST_RUN  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        MD_INTERNAL = 2'd0,
        MD_BUFFERED = 2'd1,
        MD_HIZ      = 2'd2,
        MD_TEST     = 2'd3
    } clk_mode_e;

    typedef struct packed {
        logic [1:0] s2;
        logic [1:0] fs;
        logic       mult;
    } strap_t;

    localparam logic [1:0] S2_LOW = 2'b00;
    localparam logic [1:0] S2_MID = 2'b01;

    localparam logic [9:0] TEST_DIVS = {2'd1, 2'd0, 2'd3, 2'd2, 2'd1};

    function automatic clk_mode_e mode_of(input strap_t s);
        if (s.s2 == S2_LOW)      return MD_INTERNAL;
        else if (s.s2 == S2_MID) return (s.fs == 2'b01) ? MD_TEST : MD_HIZ;
        else                     return MD_BUFFERED;
    endfunction

    function automatic logic [7:0] mhz_of(input logic [1:0] fs);
        case (fs)
            2'b00:   return 8'd66;
            2'b01:   return 8'd100;
            2'b10:   return 8'd200;
            default: return 8'd133;
        endcase
    endfunction

endpackage

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic supply_good,
    input  logic strap_valid_n,
    input  logic dly_done,
    output logic capture,
    output logic cnt_en,
    output logic pll_en,
    output logic out_en
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_OFF:  if (supply_good) state_d = ST_WAIT;
            ST_WAIT: if (!supply_good) state_d = ST_OFF;
                     else if (!strap_valid_n) state_d = ST_LOCK;
            ST_LOCK: if (!supply_good) state_d = ST_OFF;
                     else if (dly_done) state_d = ST_RUN;
            ST_RUN:  if (!supply_good) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end

    assign capture = (state_q == ST_WAIT) && supply_good && !strap_valid_n;
    assign cnt_en  = (state_q == ST_LOCK);
    assign pll_en  = (state_q == ST_LOCK) || (state_q == ST_RUN);
    assign out_en  = (state_q == ST_RUN);
endmodule

// File: rtl/pwrseq_delay_cnt.sv
module pwrseq_delay_cnt #(
    parameter int DLY = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic done
);
    localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) cnt_q <= '0;
        else            cnt_q <= cnt_q + 1'b1;
    end

    assign done = en && (cnt_q == LAST);
endmodule

// File: rtl/pwrseq_strap_latch.sv
module pwrseq_strap_latch
    import pwrseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  strap_t straps_in,
    output strap_t straps_q
);
    always_ff @(posedge clk) begin
        if (rst)       straps_q <= '0;
        else if (load) straps_q <= straps_in;
    end
endmodule

// File: rtl/pwrseq_mode_dec.sv
module pwrseq_mode_dec
    import pwrseq_pkg::*;
(
    input  strap_t      straps,
    output clk_mode_e   mode,
    output logic [7:0]  mhz,
    output logic [9:0]  tdiv
);
    always_comb begin
        mode = mode_of(straps);
        mhz  = '0;
        tdiv = '0;
        case (mode)
            MD_INTERNAL, MD_BUFFERED: mhz  = mhz_of(straps.fs);
            MD_TEST:                  tdiv = TEST_DIVS;
            default: ;
        endcase
    end
endmodule

// File: rtl/pwrseq_strap_top.sv
module pwrseq_strap_top
    import pwrseq_pkg::*;
#(
    parameter int DLY = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_good,
    input  logic       strap_valid_n,
    input  logic [1:0] sel_s2,
    input  logic [1:0] sel_fs,
    input  logic       mult_sel,
    output logic       pll_en,
    output logic       out_en,
    output logic [1:0] clk_mode,
    output logic [7:0] cpu_mhz,
    output logic [9:0] tdiv_log2,
    output logic       mult_lat
);
    logic      capture, cnt_en, dly_done;
    strap_t    straps_in, straps_q;
    clk_mode_e mode;

    assign straps_in = '{s2: sel_s2, fs: sel_fs, mult: mult_sel};

    pwrseq_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .supply_good   (supply_good),
        .strap_valid_n (strap_valid_n),
        .dly_done      (dly_done),
        .capture       (capture),
        .cnt_en        (cnt_en),
        .pll_en        (pll_en),
        .out_en        (out_en)
    );

    pwrseq_delay_cnt #(.DLY(DLY)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .en   (cnt_en),
        .done (dly_done)
    );

    pwrseq_strap_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .load      (capture),
        .straps_in (straps_in),
        .straps_q  (straps_q)
    );

    pwrseq_mode_dec u_dec (
        .straps (straps_q),
        .mode   (mode),
        .mhz    (cpu_mhz),
        .tdiv   (tdiv_log2)
    );

    assign clk_mode = mode;
    assign mult_lat = straps_q.mult;
endmodule

// File: rtl/pwrseq_strap_chk.sv
module pwrseq_strap_chk #(
    parameter int DLY = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       supply_good,
    input logic       strap_valid_n,
    input logic       pll_en,
    input logic       out_en,
    input logic [1:0] clk_mode,
    input logic [7:0] cpu_mhz,
    input logic [9:0] tdiv_log2,
    input logic       mult_lat
);
    localparam int CW = $clog2(DLY + 2);
    localparam logic [CW-1:0] SAT = CW'(DLY + 1);

    logic [CW-1:0] since_pll;

    always_ff @(posedge clk) begin
        if (rst || !pll_en)    since_pll <= '0;
        else if (since_pll != SAT) since_pll <= since_pll + 1'b1;
    end

    a_r1_supply_off: assert property (@(posedge clk) disable iff (rst)
        !supply_good |=> (!pll_en && !out_en));

    a_r2_start_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_en) |-> ($past(supply_good) && !$past(strap_valid_n)));

    a_r3_out_implies_pll: assert property (@(posedge clk) disable iff (rst)
        out_en |-> pll_en);

    a_r3_delay_exact: assert property (@(posedge clk) disable iff (rst)
        $rose(out_en) |-> (since_pll == CW'(DLY)));

    a_r5_hold_straps: assert property (@(posedge clk) disable iff (rst)
        (pll_en && $past(pll_en)) |->
            ($stable(clk_mode) && $stable(cpu_mhz) && $stable(tdiv_log2) && $stable(mult_lat)));

    a_r8_hiz_no_freq: assert property (@(posedge clk) disable iff (rst)
        (clk_mode == 2'd2) |-> (cpu_mhz == 8'd0 && tdiv_log2 == 10'd0));
endmodule

bind pwrseq_strap_top pwrseq_strap_chk #(.DLY(DLY)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .supply_good   (supply_good),
    .strap_valid_n (strap_valid_n),
    .pll_en        (pll_en),
    .out_en        (out_en),
    .clk_mode      (clk_mode),
    .cpu_mhz       (cpu_mhz),
    .tdiv_log2     (tdiv_log2),
    .mult_lat      (mult_lat)
);

// File: tb/pwrseq_strap_top_tb.sv
module pwrseq_strap_top_tb;
    localparam int DLY = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_good = 1'b0;
    logic       strap_valid_n = 1'b1;
    logic [1:0] sel_s2 = 2'b00;
    logic [1:0] sel_fs = 2'b00;
    logic       mult_sel = 1'b0;
    logic       pll_en, out_en, mult_lat;
    logic [1:0] clk_mode;
    logic [7:0] cpu_mhz;
    logic [9:0] tdiv_log2;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pwrseq_strap_top #(.DLY(DLY)) u_dut (
        .clk(clk), .rst(rst), .supply_good(supply_good), .strap_valid_n(strap_valid_n),
        .sel_s2(sel_s2), .sel_fs(sel_fs), .mult_sel(mult_sel),
        .pll_en(pll_en), .out_en(out_en), .clk_mode(clk_mode),
        .cpu_mhz(cpu_mhz), .tdiv_log2(tdiv_log2), .mult_lat(mult_lat)
    );

    function automatic int exp_mode(input logic [1:0] s2, input logic [1:0] fs);
        if (s2 == 2'b00) return 0;
        if (s2 == 2'b01) return (fs == 2'b01) ? 3 : 2;
        return 1;
    endfunction

    function automatic int exp_mhz(input logic [1:0] s2, input logic [1:0] fs);
        if (exp_mode(s2, fs) >= 2) return 0;
        case (fs)
            2'b00:   return 66;
            2'b01:   return 100;
            2'b10:   return 200;
            default: return 133;
        endcase
    endfunction

    function automatic int exp_tdiv(input logic [1:0] s2, input logic [1:0] fs);
        return (exp_mode(s2, fs) == 3) ? 10'b01_00_11_10_01 : 0;
    endfunction

    function automatic string mode_tag(input logic [1:0] s2, input logic [1:0] fs);
        case (exp_mode(s2, fs))
            0:       return "R6";
            1:       return "R7";
            2:       return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic scramble();
        sel_s2 = 2'($urandom);
        sel_fs = 2'($urandom);
        mult_sel = 1'($urandom);
    endtask

    task automatic check_decode(input logic [1:0] s2, input logic [1:0] fs, input logic m, input string pfx);
        string t;
        t = mode_tag(s2, fs);
        chk({pfx, t, " clk_mode"}, int'(clk_mode), exp_mode(s2, fs));
        chk({pfx, t, " cpu_mhz"}, int'(cpu_mhz), exp_mhz(s2, fs));
        chk({pfx, t, " tdiv_log2"}, int'(tdiv_log2), exp_tdiv(s2, fs));
        chk({pfx, "R10 mult_lat"}, int'(mult_lat), int'(m));
    endtask

    task automatic full_seq(input logic [1:0] s2, input logic [1:0] fs, input logic m);
        int k;
        @(negedge clk);
        supply_good = 1'b1; strap_valid_n = 1'b1; scramble();
        repeat (2 + ($urandom % 4)) @(negedge clk);
        chk("R2 no start before strobe", int'(pll_en), 0);
        sel_s2 = s2; sel_fs = fs; mult_sel = m; strap_valid_n = 1'b0;
        @(negedge clk);
        chk("R2 pll_en after strobe", int'(pll_en), 1);
        strap_valid_n = 1'b1; sel_s2 = ~s2; sel_fs = ~fs; mult_sel = ~m;
        k = 0;
        while (!out_en && k < DLY + 8) begin
            if (!pll_en) chk("R3 pll_en held in wait", 0, 1);
            k++;
            @(negedge clk);
        end
        chk("R3 enable delay", k, DLY);
        chk("R3 pll_en with out_en", int'(pll_en), 1);
        check_decode(s2, fs, m, "");
        sel_s2 = ~s2; sel_fs = fs ^ 2'b01; strap_valid_n = 1'b0;
        repeat (2) @(negedge clk);
        strap_valid_n = 1'b1; scramble();
        @(negedge clk);
        check_decode(s2, fs, m, "R5 hold ");
        supply_good = 1'b0;
        @(negedge clk);
        chk("R4 pll_en after drop", int'(pll_en), 0);
        chk("R4 out_en after drop", int'(out_en), 0);
    endtask

    initial begin
        int seed_val;
        seed_val = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        chk("R1 reset pll_en", int'(pll_en), 0);
        chk("R1 reset out_en", int'(out_en), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle pll_en", int'(pll_en), 0);

        // strobe low while supply is low: no start
        strap_valid_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 strobe without supply", int'(pll_en), 0);
        strap_valid_n = 1'b1;

        // directed: every select combination
        for (int s = 0; s < 4; s++)
            for (int f = 0; f < 4; f++)
                full_seq(2'(s), 2'(f), 1'(f[0] ^ s[1]));

        // supply drop during the enable delay
        @(negedge clk);
        supply_good = 1'b1; strap_valid_n = 1'b1;
        repeat (2) @(negedge clk);
        sel_s2 = 2'b00; sel_fs = 2'b10; strap_valid_n = 1'b0;
        @(negedge clk);
        strap_valid_n = 1'b1;
        repeat (3) @(negedge clk);
        supply_good = 1'b0;
        @(negedge clk);
        chk("R4 drop mid-wait pll_en", int'(pll_en), 0);
        supply_good = 1'b1;
        repeat (DLY + 4) @(negedge clk);
        chk("R4 no restart without strobe pll_en", int'(pll_en), 0);
        chk("R4 no restart without strobe out_en", int'(out_en), 0);
        supply_good = 1'b0;
        @(negedge clk);
        chk("R1 off after supply low", int'(pll_en), 0);

        // random sequences
        for (int i = 0; i < 24; i++)
            full_seq(2'($urandom), 2'($urandom), 1'($urandom));

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule